// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Arbiter

The arbiter collects request flags from sixteen peripheral conditions, qualifies each with its own enable, and folds them onto eleven request lines. Three of those lines are shared: all serial error conditions land on one line, the two receive conditions on another, and the two transmit conditions on a third. A software-interrupt strobe adds a twelfth candidate. It has the highest priority and is the only one that the global CPU mask cannot hold back.

When no request is outstanding, the block picks the highest-priority candidate. It raises its request output and latches that candidate's fixed vector address. Both stay frozen until the CPU acknowledges, so a late arrival cannot change the vector in the middle of a fetch. Two read-only status words report which request lines are active. These words ignore the global mask, so pending sources stay visible to debug software while interrupts are masked.

Top module: `prio_irq_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `irq_o` is 0, `vec_o` is 0 and both status words read 0.
- R2: Source index map for `src_flag_i`/`src_en_i`. The direct sources are 0 external pin, 1 clock monitor, 2 timer channel 0, 3 timer channel 1, 4 timer overflow, 13 keyboard, 14 ADC done and 15 timebase. The serial sources are 5 overrun, 6 noise, 7 framing, 8 parity, 9 receiver full, 10 receiver idle, 11 transmitter empty and 12 transmission complete. A source counts only when both its flag and its enable are 1.
- R3: The serial error line is active when any of sources 5..8 is qualified. The serial receive line is active when source 9 or 10 is qualified. The serial transmit line is active when source 11 or 12 is qualified.
- R4: With `stat_sel_i`=0 the status word puts lines 1..5 (pin, clock monitor, channel 0, channel 1, overflow) in bits 2..6. Bits 7, 1 and 0 read 0.
- R5: With `stat_sel_i`=1 the status word puts the serial error, serial receive, serial transmit, keyboard, ADC and timebase lines in bits 0..5. Bits 6 and 7 read 0.
- R6: Status bits follow the qualified lines one cycle after the inputs and do not depend on `gmask_i`.
- R7: While `gmask_i`=1, no source other than the software interrupt raises `irq_o`.
- R8: A `swi_stb_i` pulse sets a pending bit. Two cycles after the pulse, and regardless of the mask, `irq_o` rises with vector 0xFFFC. The pending bit clears only when that software request is acknowledged, and a strobe that arrives in the acknowledge cycle keeps it set.
- R9: Lower priority number wins. Priorities are 0 software, then 1 to 11 in the line order pin, clock monitor, channel 0, channel 1, overflow, serial error, serial receive, serial transmit, keyboard, ADC, timebase. Their vectors are 0xFFFA, 0xFFF8, 0xFFF6, 0xFFF4, 0xFFF2, 0xFFE6, 0xFFE4, 0xFFE2, 0xFFE0, 0xFFDE, 0xFFDC.
- R10: When idle, an unmasked qualified source raises `irq_o` on the next clock edge. `irq_o` and `vec_o` then hold until `ack_i` is seen. `irq_o` falls on the edge that samples `ack_i`, and arbitration resumes on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_flag_i | input | 16 | Raw peripheral condition flags (R2 index map) |
| src_en_i | input | 16 | Per-source enables, same index map |
| gmask_i | input | 1 | Global CPU interrupt mask, 1 blocks |
| swi_stb_i | input | 1 | Software interrupt strobe |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| stat_sel_i | input | 1 | Selects status word 0 or 1 |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Latched vector address |
| stat_rdata_o | output | 8 | Selected status word |

## Verification
Two functions can meet in one cycle: acknowledging a software interrupt and receiving a fresh software strobe. The bench waits for the monitor to drive the acknowledge, then pulses the strobe so that both are sampled on the same edge. The pending bit must survive, so the scoreboard expects a second 0xFFFC delivery and no spurious request after it. A separate case has a higher-priority source arrive while a request is held and the acknowledge is delayed. The monitor checks that the vector stays unchanged until the acknowledge, and that the new source wins only afterwards.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int NSRC   = 16;
    localparam int NLINES = 11;
    localparam int NCAND  = NLINES + 1;
    localparam int IDX_W  = $clog2(NCAND);
    localparam int VEC_W  = 16;
    localparam int STAT_W = 8;

    typedef struct packed {
        logic              irq;
        logic [IDX_W-1:0]  win;
        logic [VEC_W-1:0]  vec;
        logic              swi_pend;
        logic [NLINES-1:0] lines;
    } arb_state_t;

    // Priority 0..5 step down from 0xFFFC, 6..11 step down from 0xFFE6
    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [VEC_W-1:0] off;
        off = VEC_W'(idx) << 1;
        if (idx <= IDX_W'(5))
            vec_of = 16'hFFFC - off;
        else
            vec_of = 16'hFFF2 - off;
    endfunction
endpackage

// File: rtl/irq_line_gather.sv
module irq_line_gather
    import irq_arb_pkg::*;
(
    input  logic [NSRC-1:0]   flag_i,
    input  logic [NSRC-1:0]   en_i,
    output logic [NLINES-1:0] lines_o
);
    localparam int NDIRECT = 5;
    localparam int NTAIL   = 3;

    logic [NSRC-1:0] qual;
    assign qual = flag_i & en_i;

    for (genvar g = 0; g < NDIRECT; g++) begin : g_direct
        assign lines_o[g] = qual[g];
    end

    assign lines_o[5] = |qual[8:5];
    assign lines_o[6] = |qual[10:9];
    assign lines_o[7] = |qual[12:11];

    for (genvar t = 0; t < NTAIL; t++) begin : g_tail
        assign lines_o[8+t] = qual[13+t];
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 12,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import irq_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_flag_i,
    input  logic [NSRC-1:0]   src_en_i,
    input  logic              gmask_i,
    input  logic              swi_stb_i,
    input  logic              ack_i,
    input  logic              stat_sel_i,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [STAT_W-1:0] stat_rdata_o
);
    arb_state_t        st_d, st_q;
    logic [NLINES-1:0] lines_now;
    logic [NCAND-1:0]  cand;
    logic              pick_valid;
    logic [IDX_W-1:0]  pick_idx;

    irq_line_gather u_gather (
        .flag_i  (src_flag_i),
        .en_i    (src_en_i),
        .lines_o (lines_now)
    );

    assign cand = {lines_now & ~{NLINES{gmask_i}}, st_q.swi_pend};

    irq_prio_pick #(.N(NCAND), .IW(IDX_W)) u_pick (
        .req_i   (cand),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    always_comb begin
        st_d          = st_q;
        st_d.lines    = lines_now;
        st_d.swi_pend = st_q.swi_pend | swi_stb_i;
        if (st_q.irq) begin
            if (ack_i) begin
                st_d.irq = 1'b0;
                if (st_q.win == '0)
                    st_d.swi_pend = swi_stb_i;
            end
        end else if (pick_valid) begin
            st_d.irq = 1'b1;
            st_d.win = pick_idx;
            st_d.vec = vec_of(pick_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign irq_o = st_q.irq;
    assign vec_o = st_q.vec;

    always_comb begin
        if (stat_sel_i)
            stat_rdata_o = {2'b00, st_q.lines[10:5]};
        else
            stat_rdata_o = {1'b0, st_q.lines[4:0], 2'b00};
    end

    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

    a_r10_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);

    a_r8_swi_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && st_q.swi_pend) |=> (irq_o && vec_o == 16'hFFFC));

    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !st_q.swi_pend && gmask_i) |=> !irq_o);
endmodule

// File: tb/prio_irq_arbiter_tb.sv
module prio_irq_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] src_flag, src_en;
    logic        gmask, swi_stb, ack, stat_sel;
    logic        irq;
    logic [15:0] vec;
    logic [7:0]  stat;

    int n_chk = 0;
    int n_fail = 0;
    int ack_delay = 0;
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    prio_irq_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .src_flag_i(src_flag), .src_en_i(src_en),
        .gmask_i(gmask), .swi_stb_i(swi_stb), .ack_i(ack), .stat_sel_i(stat_sel),
        .irq_o(irq), .vec_o(vec), .stat_rdata_o(stat)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: pops expected vectors when the request is seen, then acknowledges
    initial begin
        ack = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && irq) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7/R10 unexpected request", vec, 16'h0000);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(vec == e, "R9 vector", vec, e);
                    for (int k = 0; k < ack_delay; k++) begin
                        @(negedge clk);
                        chk(irq && vec == e, "R10 held vector", vec, e);
                    end
                end
                ack = 1'b1;
                @(negedge clk);
                ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", 16'h0, 16'h0);
        finish_run();
    end

    task automatic stat_chk(input logic [15:0] f, input logic [15:0] e, input bit sel,
                            input logic [7:0] exp, input string req);
        src_flag = f; src_en = e; stat_sel = sel;
        @(negedge clk); @(negedge clk);
        chk(stat == exp, req, {8'h0, stat}, {8'h0, exp});
    endtask

    task automatic serve(input logic [15:0] f, input logic [15:0] exp);
        exp_q.push_back(exp);
        src_flag = f;
        while (exp_q.size() != 0) @(negedge clk);
        src_flag = '0;
        repeat (3) @(negedge clk);
    endtask

    localparam logic [15:0] VEC_TAB [11] = '{16'hFFFA, 16'hFFF8, 16'hFFF6, 16'hFFF4, 16'hFFF2,
                                             16'hFFE6, 16'hFFE4, 16'hFFE2, 16'hFFE0, 16'hFFDE, 16'hFFDC};
    localparam int SRC_TAB [11] = '{0, 1, 2, 3, 4, 7, 9, 11, 13, 14, 15};

    initial begin
        rst_n = 1'b0; src_flag = '0; src_en = '1; gmask = 1'b1;
        swi_stb = 1'b0; stat_sel = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(irq == 1'b0, "R1 irq", {15'h0, irq}, 16'h0);
        chk(vec == 16'h0, "R1 vec", vec, 16'h0);
        chk(stat == 8'h0, "R1 status0", {8'h0, stat}, 16'h0);
        stat_sel = 1'b1; #1;
        chk(stat == 8'h0, "R1 status1", {8'h0, stat}, 16'h0);
        stat_sel = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0 && stat == 8'h0, "R1 after reset", {8'h0, stat}, 16'h0);

        // Status words, mask held at 1 (R6: status ignores the mask)
        stat_chk(16'h0001, 16'hFFFF, 1'b0, 8'h04, "R4 pin bit2");
        stat_chk(16'h0012, 16'hFFFF, 1'b0, 8'h48, "R4 clkmon+ovf bits3,6");
        stat_chk(16'h001F, 16'hFFFF, 1'b0, 8'h7C, "R4 all direct, bits 7,1,0 zero");
        stat_chk(16'h0040, 16'hFFFF, 1'b1, 8'h01, "R3 noise on error line");
        stat_chk(16'h0400, 16'hFFFF, 1'b1, 8'h02, "R3 rx idle on receive line");
        stat_chk(16'h1000, 16'hFFFF, 1'b1, 8'h04, "R3 tx complete on transmit line");
        stat_chk(16'hE000, 16'hFFFF, 1'b1, 8'h38, "R5 kbd/adc/timebase bits3..5");
        stat_chk(16'hFFFF, 16'hFFFF, 1'b1, 8'h3F, "R5 bits 6,7 zero");
        stat_chk(16'hFFFF, 16'h0000, 1'b0, 8'h00, "R2 disabled sources ignored");
        stat_chk(16'h0020, 16'hFFDF, 1'b1, 8'h00, "R2 overrun gated off");
        chk(irq == 1'b0, "R6/R7 masked, no request during status tests", {15'h0, irq}, 16'h0);
        src_en = '1;

        // R7 mask holds a pending source back
        src_flag = 16'h0001;
        repeat (8) @(negedge clk);
        chk(irq == 1'b0, "R7 masked pin", {15'h0, irq}, 16'h0);
        exp_q.push_back(16'hFFFA);
        gmask = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        src_flag = '0;
        repeat (3) @(negedge clk);

        // R9 vector table, one source per line
        for (int i = 0; i < 11; i++) serve(16'(1) << SRC_TAB[i], VEC_TAB[i]);

        // R9 priority order with three simultaneous sources
        exp_q.push_back(16'hFFF2); exp_q.push_back(16'hFFE0); exp_q.push_back(16'hFFDC);
        src_flag = 16'hA010;
        while (exp_q.size() > 2) @(negedge clk);
        src_flag[4] = 1'b0;
        while (exp_q.size() > 1) @(negedge clk);
        src_flag[13] = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        src_flag = '0;
        repeat (3) @(negedge clk);

        // R10 vector held while a higher-priority source arrives
        ack_delay = 4;
        exp_q.push_back(16'hFFF6);
        src_flag = 16'h0004;
        while (exp_q.size() != 0) @(negedge clk);
        exp_q.push_back(16'hFFFA);
        src_flag = 16'h0001;
        while (exp_q.size() != 0) @(negedge clk);
        src_flag = '0;
        ack_delay = 0;
        repeat (8) @(negedge clk);

        // R8 software interrupt under mask, new strobe in the acknowledge cycle
        gmask = 1'b1;
        src_flag = 16'h0001;
        exp_q.push_back(16'hFFFC); exp_q.push_back(16'hFFFC);
        swi_stb = 1'b1;
        @(negedge clk);
        swi_stb = 1'b0;
        @(posedge ack);
        swi_stb = 1'b1;
        @(negedge clk);
        swi_stb = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(irq == 1'b0, "R8 pending cleared after second acknowledge", {15'h0, irq}, 16'h0);
        chk(exp_q.size() == 0, "R8 all software deliveries seen", 16'(exp_q.size()), 16'h0);
        src_flag = '0;
        finish_run();
    end
endmodule